// File: doc/BRIEF.md
# Write Status Polling Generator

While a memory's internal program or erase is running, a host cannot read the array. It reads back a status byte instead, and keeps reading until that byte shows the operation has finished. This block forms that status byte. It sits between the array read path and the data output. It watches an operation start strobe, the busy flag from the internal write engine, the operation type, the byte being programmed and the active-low output enable.

A start strobe arms the block. The strobe is the synchronous image of the write-enable rising edge that launches the internal operation. While the block is armed and the engine is busy, every read returns a status byte. The top bit is a polling bit. It is the inverse of the top bit of the programmed byte for a program, and zero for an erase. The next bit down is a toggle bit that inverts after each finished status read. All lower bits are zero.

The busy state is frozen when a read begins, so a read that overlaps completion returns one consistent byte. Once the engine drops busy, the block disarms and reads pass the array data through again.

Top module: `wr_status_poll`

## Requirements
- R1: After reset (rstN low), dataOut is 0, the block is disarmed, and the toggle bit is 0. A read after reset returns arrayData.
- R2: A one-cycle startPulse arms the block and captures opErase and the top bit of progData. Status bytes are returned only by reads that begin while the block is armed and busyIn is 1. Without an arming pulse, busyIn alone does not select status.
- R3: During a status read of a program operation (opErase captured as 0), bit DATA_W-1 of dataOut is the inverse of the captured top bit of progData.
- R4: During a status read of an erase operation (opErase captured as 1), bit DATA_W-1 of dataOut is 0.
- R5: Bit DATA_W-2 of dataOut is the toggle bit. It is cleared by each arming pulse and inverts when a status read ends (oeN sampled high again). Normal reads leave it unchanged.
- R6: During a status read, bits DATA_W-3 down to 0 of dataOut are 0.
- R7: Whether a read returns status is decided from the armed state and busyIn in the cycle the read begins. The byte then stays the same for the whole read, even if busyIn falls during it.
- R8: The block disarms on the cycle after busyIn is sampled falling. Reads that begin after that return arrayData, and the toggle bit no longer changes.
- R9: A startPulse while the block is armed is ignored: the captured operation type, the captured data bit and the toggle bit keep their values.
- R10: dataOut is valid from the first clock edge that samples oeN low. It is 0 from the first clock edge that samples oeN high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle strobe that launches an internal operation |
| busyIn | input | 1 | Internal write engine busy flag |
| opErase | input | 1 | Operation type at start: 1 for erase, 0 for program |
| progData | input | DATA_W | Byte being programmed, captured at start |
| arrayData | input | DATA_W | Normal array read data |
| oeN | input | 1 | Active-low output enable, one low period per read |
| dataOut | output | DATA_W | Read data: status byte, array data, or 0 when idle |

## Verification
The first valid read byte appears after the first rising edge that samples oeN low, and dataOut returns to 0 after the edge that samples oeN high. Arming takes effect one edge after the start strobe, and disarming one edge after busyIn is seen falling. A toggle update shows only in the next read. The bench drives its inputs 2 ns after a rising edge and samples at the falling edge. It compares the output against a behavioural model updated on each rising edge, and directed reads check literal bytes in the sampling cycle worked out from these latencies.

// File: rtl/wr_status_poll_pkg.sv
package wr_status_poll_pkg;

  // strobes from the control to the datapath
  typedef struct packed {
    logic captureOp;   // arm: latch operation type and data bit
    logic readBegin;   // first cycle oe sampled low
    logic readEnd;     // first cycle oe sampled high after a read
    logic clearArm;    // engine finished
  } pollStrobeT;

endpackage

// File: rtl/wr_status_poll_ctrl.sv
module wr_status_poll_ctrl
  import wr_status_poll_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       busyIn,
  input  logic       oeN,
  output pollStrobeT strb,
  output logic       armed,
  output logic       readActive
);

  logic busyPrev;
  logic oeLow;

  assign oeLow = ~oeN;

  always_comb begin
    strb.captureOp = startPulse & ~armed;
    strb.clearArm  = armed & busyPrev & ~busyIn;
    strb.readBegin = oeLow & ~readActive;
    strb.readEnd   = ~oeLow & readActive;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyPrev   <= 1'b0;
      armed      <= 1'b0;
      readActive <= 1'b0;
    end else begin
      busyPrev <= busyIn;
      if (strb.captureOp) armed <= 1'b1;
      else if (strb.clearArm) armed <= 1'b0;
      if (strb.readBegin) readActive <= 1'b1;
      else if (strb.readEnd) readActive <= 1'b0;
    end
  end

  // R9: a start while armed leaves the block armed
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (armed && startPulse) |=> armed);

  // R8: falling busy disarms on the next edge
  a_r8_disarm: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $fell(busyIn) && !startPulse) |=> !armed);

  // R10: read phase follows oe one edge later
  a_r10_read_phase: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |=> readActive);

endmodule

// File: rtl/wr_status_poll_dp.sv
module wr_status_poll_dp
  import wr_status_poll_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollStrobeT        strb,
  input  logic              armed,
  input  logic              readActive,
  input  logic              busyIn,
  input  logic              opErase,
  input  logic [DATA_W-1:0] progData,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dataOut
);

  localparam int POLL_POS = DATA_W - 1;
  localparam int TOG_POS  = DATA_W - 2;

  logic eraseQ;
  logic topBitQ;
  logic toggleQ;
  logic snapActive;
  logic pollBit;
  logic [DATA_W-1:0] statusByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eraseQ     <= 1'b0;
      topBitQ    <= 1'b0;
      toggleQ    <= 1'b0;
      snapActive <= 1'b0;
    end else begin
      if (strb.captureOp) begin
        eraseQ  <= opErase;
        topBitQ <= progData[POLL_POS];
      end
      if (strb.captureOp) toggleQ <= 1'b0;
      else if (strb.readEnd && snapActive) toggleQ <= ~toggleQ;
      if (strb.readBegin) snapActive <= armed & busyIn;
      else if (strb.readEnd) snapActive <= 1'b0;
    end
  end

  assign pollBit = eraseQ ? 1'b0 : ~topBitQ;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_status
      if (i == POLL_POS) begin : g_poll
        assign statusByte[i] = pollBit;
      end else if (i == TOG_POS) begin : g_tog
        assign statusByte[i] = toggleQ;
      end else begin : g_zero
        assign statusByte[i] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    if (!readActive) dataOut = '0;
    else if (snapActive) dataOut = statusByte;
    else dataOut = arrayData;
  end

  // R5: the toggle bit moves only at a status read end or an arming
  a_r5_toggle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.readEnd && snapActive) && !strb.captureOp |=> $stable(toggleQ));

  // R7: the snapshot is held for the whole read
  a_r7_snapshot_stable: assert property (@(posedge clk) disable iff (!rstN)
    (readActive && !strb.readEnd) |=> $stable(snapActive));

  // R9: an ignored start leaves the captured operation alone
  a_r9_capture_hold: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !strb.captureOp) |=> ($stable(eraseQ) && $stable(topBitQ)));

endmodule

// File: rtl/wr_status_poll.sv
module wr_status_poll
  import wr_status_poll_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              busyIn,
  input  logic              opErase,
  input  logic [DATA_W-1:0] progData,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              oeN,
  output logic [DATA_W-1:0] dataOut
);

  pollStrobeT strb;
  logic armed;
  logic readActive;

  wr_status_poll_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .busyIn(busyIn),
    .oeN(oeN), .strb(strb), .armed(armed), .readActive(readActive)
  );

  wr_status_poll_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .armed(armed),
    .readActive(readActive), .busyIn(busyIn), .opErase(opErase),
    .progData(progData), .arrayData(arrayData), .dataOut(dataOut)
  );

  // R10: an idle bus reads zero one edge after oe is seen high
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    oeN |=> (dataOut == '0));

  // R6: low bits of a status byte are zero while reading with the block armed and busy
  a_r6_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.readBegin && armed && busyIn) |=> (dataOut[DATA_W-3:0] == '0));

endmodule

// File: tb/sim_wr_status_poll.sv
module sim_wr_status_poll;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0, busyIn = 1'b0, opErase = 1'b0, oeN = 1'b1;
  logic [W-1:0] progData = '0, arrayData = 8'h5A;
  logic [W-1:0] dataOut;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wr_status_poll #(.DATA_W(W)) u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .busyIn(busyIn),
    .opErase(opErase), .progData(progData), .arrayData(arrayData),
    .oeN(oeN), .dataOut(dataOut)
  );

  // behavioural reference model, updated on each rising edge
  bit mArmed, mErase, mTop, mTog, mBusyPrev, mRead, mStatus;
  always @(posedge clk) begin
    if (!rstN) begin
      mArmed = 0; mErase = 0; mTop = 0; mTog = 0;
      mBusyPrev = 0; mRead = 0; mStatus = 0;
    end else begin
      bit wasArmed;
      wasArmed = mArmed;
      if (!oeN && !mRead) begin
        mRead = 1; mStatus = wasArmed && busyIn;
      end else if (oeN && mRead) begin
        if (mStatus && !(startPulse && !wasArmed)) mTog = !mTog;
        mRead = 0; mStatus = 0;
      end
      if (startPulse && !wasArmed) begin
        mArmed = 1; mErase = opErase; mTop = progData[W-1]; mTog = 0;
      end else if (wasArmed && mBusyPrev && !busyIn) begin
        mArmed = 0;
      end
      mBusyPrev = busyIn;
    end
  end

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: dataOut=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (!done) begin
      logic [W-1:0] exp;
      string tag;
      if (!rstN) begin exp = '0; tag = "R1"; end
      else if (!mRead) begin exp = '0; tag = "R10"; end
      else if (mStatus) begin
        exp = {(mErase ? 1'b0 : !mTop), mTog, {(W-2){1'b0}}};
        tag = mErase ? "R4" : "R3";
      end else begin exp = arrayData; tag = "R8"; end
      check(tag, dataOut, exp);
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic arm(input logic er, input logic [W-1:0] d);
    step(); startPulse = 1; opErase = er; progData = d;
    step(); startPulse = 0;
  endtask

  // one full read, returns the byte seen in its first valid cycle
  task automatic readByte(output logic [W-1:0] got);
    step(); oeN = 0;
    @(posedge clk); @(negedge clk); got = dataOut;
    step(); oeN = 1;
    step();
  endtask

  initial begin
    logic [W-1:0] v;
    repeat (3) step();
    check("R1", dataOut, 8'h00);
    rstN = 1;
    step();
    readByte(v); check("R1", v, 8'h5A);
    // R2: busy without arming is a normal read
    busyIn = 1; step();
    readByte(v); check("R2", v, 8'h5A);
    busyIn = 0; step(); step();
    // program, top bit 0 -> polling bit 1
    arm(0, 8'h35); busyIn = 1;
    readByte(v); check("R3", v, 8'h80);
    readByte(v); check("R5", v, 8'hC0);
    readByte(v); check("R6", v, 8'h80);
    // R9: start while armed is ignored
    arm(1, 8'hFF);
    readByte(v); check("R9", v, 8'hC0);
    // R7: busy falls mid-read
    step(); oeN = 0;
    @(posedge clk); @(negedge clk); check("R7", dataOut, 8'h80);
    step(); busyIn = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); check("R7", dataOut, 8'h80);
    step(); oeN = 1; step();
    arrayData = 8'h3C;
    readByte(v); check("R8", v, 8'h3C);
    // R2: start without busy gives normal reads
    arm(0, 8'h00);
    readByte(v); check("R2", v, 8'h3C);
    busyIn = 1; step(); busyIn = 0; step(); step();
    // erase operation
    arm(1, 8'hFF); busyIn = 1;
    readByte(v); check("R4", v, 8'h00);
    readByte(v); check("R5", v, 8'h40);
    arrayData = 8'hA5; step();
    readByte(v); check("R4", v, 8'h00);
    busyIn = 0; step(); step();
    readByte(v); check("R8", v, 8'hA5);
    step(); step();
    check("R10", dataOut, 8'h00);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R10: watchdog expired, dataOut=%h expected=finished run", dataOut);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule